// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the serial-peripheral slave front end that owns the 8-bit status register of a serial flash device. It oversamples the serial clock, chip select and serial input on the system clock. It works in SPI mode 0 and mode 3. It decodes six opcodes: set write latch, clear write latch, status read, status write, program and erase. The status write only writes the protect fields.

A status read keeps streaming the live register value, one byte after another, for as long as chip select stays low. Because each byte is reloaded, a status read that is already running shows the busy bit dropping when an operation ends.

Write-class commands are the status write, program and erase. Each one executes only when chip select rises exactly on a byte boundary. At that point the block either accepts the command or rejects it, and reports the outcome on a one-cycle accept strobe or a one-cycle reject strobe. An accepted command starts an internal busy engine. This engine is a counter that runs for a programmable number of system clock cycles. When it finishes, the write latch clears. For a program or erase, the engine's fault input can also be latched into an error bit at that point. Pad-level tristating of the serial output is left to the pad ring: the block provides the data bit and its enable.

Top module: `flash_sr_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the serial output enable is low and neither strobe fires.
- R2: The status read opcode is 0x05. After it, the status byte is driven MSB first, one bit per SCK falling edge. Bit 0 is busy, bit 1 is the write latch, bits 4:2 are the three protect bits, bit 5 is erase error, bit 6 is program error and bit 7 is the status-write lock.
- R3: While chip select stays low, the status byte repeats. Each repeat takes the live value at the start of that byte.
- R4: The status read works at any time, including while the busy bit is 1.
- R5: Opcode 0x06 sets the write latch and 0x04 clears it. Each takes effect only in a frame of exactly one whole byte while the busy bit is 0; otherwise it is ignored.
- R6: An accepted status write has opcode 0x01 and a frame of exactly two bytes. It copies data bits 7 and 4:2 into the register and leaves bits 6, 5, 1 and 0 untouched by the data; data bit 1 never sets the write latch.
- R7: A write-class command that arrives while the write latch is 0 gives a reject strobe and changes no register bit.
- R8: An accepted write-class command gives an accept strobe. The busy bit then stays 1 for busy_len system cycles (0 counts as 1). When the busy bit falls, the write latch is cleared.
- R9: A status write is rejected when bit 7 is 1 and wp_n is low. It is allowed when bit 7 is 0 or wp_n is high.
- R10: When chip select rises off a byte boundary, the frame is aborted: no strobe and no register change.
- R11: Program (0x02) needs at least four whole bytes and erase (0x20) needs exactly four. Accepting either clears both error bits. If eng_fault is high when that operation finishes, bit 6 (program) or bit 5 (erase) is set.
- R12: Mode 0 and mode 3 frames behave the same. The output enable is high only during the data phase of a status read with chip select low.
- R13: A write-class command that arrives while the busy bit is 1 is rejected, even with the write latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| spi_sck | input | 1 | Serial clock, mode 0 or mode 3 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in, sampled on SCK rise |
| wp_n | input | 1 | Active-low write-protect pin for the status-write lock |
| busy_len | input | CNT_W | Busy engine length in system cycles |
| eng_fault | input | 1 | Engine fault flag, sampled when an operation finishes |
| spi_so | output | 1 | Serial data out, changed after SCK fall |
| spi_so_en | output | 1 | Output enable for the serial data pad |
| wr_ack | output | 1 | One-cycle strobe: write-class command accepted |
| wr_nak | output | 1 | One-cycle strobe: write-class command rejected |

## Verification
The assertions assume the serial inputs change slowly relative to clk. Each SCK level and each chip-select level is assumed to last several system cycles, and SI is assumed stable around the SCK rise. The assertions also assume that chip select never moves in the same cycle as an SCK edge. The stimulus keeps to these assumptions: it holds each SCK phase for eight system cycles and changes SI only together with the SCK fall. It also places chip-select edges well away from SCK edges, and it keeps wp_n, busy_len and eng_fault constant for the whole of an operation.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_WRDIS = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ERASE = 8'h20;

  // Field order here is the bit order seen on the serial output.
  typedef struct packed {
    logic       lock;
    logic       prog_err;
    logic       erase_err;
    logic [2:0] prot;
    logic       wlatch;
    logic       busy;
  } status_t;

  typedef enum logic [1:0] {
    JOB_WRSR  = 2'd0,
    JOB_PROG  = 2'd1,
    JOB_ERASE = 2'd2
  } job_e;

  // Only the lock and protect fields come from the data byte.
  function automatic status_t merge_wrsr(status_t cur, logic [7:0] d);
    status_t r;
    r      = cur;
    r.lock = d[7];
    r.prot = d[4:2];
    return r;
  endfunction

  function automatic logic wrsr_locked(status_t cur, logic wp_pin_n);
    return cur.lock & ~wp_pin_n;
  endfunction

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int           WIDTH   = 3,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_in;
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_out = stg[STAGES-1];

endmodule

// File: rtl/fsr_busy_engine.sv
module fsr_busy_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff_len;

  assign eff_len = (len == '0) ? ONE : len;
  assign busy    = (cnt != '0);
  assign done    = busy && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= eff_len;
    else if (busy)  cnt <= cnt - ONE;
  end

  // R8: busy drops right after the completion pulse
  a_r8_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8: a start always produces a busy window
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/fsr_spi_frontend.sv
module fsr_spi_frontend
  import flash_sr_pkg::*;
#(
  parameter int BCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              si_s,
  input  logic [7:0]        status_live,
  output logic              frame_end,
  output logic              frame_aligned,
  output logic [BCNT_W-1:0] frame_bytes,
  output logic [7:0]        frame_op,
  output logic [7:0]        frame_data,
  output logic              so_bit,
  output logic              so_oe
);

  localparam logic [BCNT_W-1:0] BCNT_MAX = '1;
  localparam logic [BCNT_W-1:0] BCNT_ONE = BCNT_W'(1);

  logic              sck_q, cs_q;
  logic              sck_rise, sck_fall, cs_rise;
  logic [2:0]        bit_idx;
  logic [7:0]        rx_sh, rx_next;
  logic [BCNT_W-1:0] byte_cnt;
  logic [7:0]        op_q, data_q;
  logic              rd_mode, tx_live;
  logic [2:0]        tx_idx;
  logic [7:0]        tx_sh;
  logic              byte_done, tx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall  = ~sck_s & sck_q & ~cs_n_s;
  assign cs_rise   = cs_n_s & ~cs_q;
  assign rx_next   = {rx_sh[6:0], si_s};
  assign byte_done = sck_rise && (bit_idx == 3'd7);
  assign tx_load   = sck_fall && rd_mode && (tx_idx == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || cs_n_s) begin
      bit_idx  <= '0;
      rx_sh    <= '0;
      byte_cnt <= '0;
      op_q     <= '0;
      data_q   <= '0;
      rd_mode  <= 1'b0;
      tx_live  <= 1'b0;
      tx_idx   <= '0;
      tx_sh    <= '0;
    end else begin
      if (sck_rise) begin
        rx_sh   <= rx_next;
        bit_idx <= bit_idx + 3'd1;
      end
      if (byte_done) begin
        if (byte_cnt != BCNT_MAX) byte_cnt <= byte_cnt + BCNT_ONE;
        if (byte_cnt == '0) begin
          op_q    <= rx_next;
          rd_mode <= (rx_next == OP_RDSR);
        end
        if (byte_cnt == BCNT_ONE) data_q <= rx_next;
      end
      if (sck_fall && rd_mode) begin
        tx_sh   <= tx_load ? status_live : {tx_sh[6:0], 1'b0};
        tx_idx  <= tx_idx + 3'd1;
        tx_live <= 1'b1;
      end
    end
  end

  assign frame_end     = cs_rise;
  assign frame_aligned = (bit_idx == 3'd0);
  assign frame_bytes   = byte_cnt;
  assign frame_op      = op_q;
  assign frame_data    = data_q;
  assign so_oe         = tx_live & ~cs_n_s;
  assign so_bit        = so_oe & tx_sh[7];

  // R3: every byte boundary of a read reloads the live register value
  a_r3_reload_live: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !$rose(cs_n_s)) |=> (tx_sh == $past(status_live)));

  // R10: chip select rising wipes the frame state and drops the output
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (bit_idx == 3'd0 && byte_cnt == '0 && !so_oe));

  // R12: output enable only after a read opcode completed
  a_r12_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> (rd_mode && op_q == OP_RDSR));

endmodule

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
  import flash_sr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STG  = 2,
  parameter int BCNT_W    = 3,
  parameter int PROG_MINB = 4,
  parameter int ERASE_B   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_si,
  input  logic             wp_n,
  input  logic [CNT_W-1:0] busy_len,
  input  logic             eng_fault,
  output logic             spi_so,
  output logic             spi_so_en,
  output logic             wr_ack,
  output logic             wr_nak
);

  localparam logic [BCNT_W-1:0] B_ONE   = BCNT_W'(1);
  localparam logic [BCNT_W-1:0] B_TWO   = BCNT_W'(2);
  localparam logic [BCNT_W-1:0] B_PROG  = BCNT_W'(PROG_MINB);
  localparam logic [BCNT_W-1:0] B_ERASE = BCNT_W'(ERASE_B);

  logic [2:0]        pins_s;
  logic              sck_s, cs_n_s, si_s;
  logic              frame_end, frame_aligned;
  logic [BCNT_W-1:0] frame_bytes;
  logic [7:0]        frame_op, frame_data;
  status_t           sr;
  logic              wip, eng_start, eng_done;
  job_e              job_q;

  fsr_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({spi_si, spi_cs_n, spi_sck}),
    .q_out (pins_s)
  );
  assign {si_s, cs_n_s, sck_s} = pins_s;

  fsr_spi_frontend #(.BCNT_W(BCNT_W)) u_front (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_s         (sck_s),
    .cs_n_s        (cs_n_s),
    .si_s          (si_s),
    .status_live   (sr),
    .frame_end     (frame_end),
    .frame_aligned (frame_aligned),
    .frame_bytes   (frame_bytes),
    .frame_op      (frame_op),
    .frame_data    (frame_data),
    .so_bit        (spi_so),
    .so_oe         (spi_so_en)
  );

  fsr_busy_engine #(.CNT_W(CNT_W)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .len   (busy_len),
    .busy  (wip),
    .done  (eng_done)
  );

  // Decoded frame events, named for the assertions.
  logic fe_ok, wren_exec, wrdis_exec;
  logic wrsr_try, prog_try, erase_try, wr_try, wr_lock, wr_grant;

  assign fe_ok      = frame_end && frame_aligned;
  assign wren_exec  = fe_ok && frame_op == OP_WREN  && frame_bytes == B_ONE && !wip;
  assign wrdis_exec = fe_ok && frame_op == OP_WRDIS && frame_bytes == B_ONE && !wip;
  assign wrsr_try   = fe_ok && frame_op == OP_WRSR  && frame_bytes == B_TWO;
  assign prog_try   = fe_ok && frame_op == OP_PROG  && frame_bytes >= B_PROG;
  assign erase_try  = fe_ok && frame_op == OP_ERASE && frame_bytes == B_ERASE;
  assign wr_try     = wrsr_try || prog_try || erase_try;
  assign wr_lock    = wrsr_try && wrsr_locked(sr, wp_n);
  assign wr_grant   = wr_try && sr.wlatch && !wip && !wr_lock;
  assign eng_start  = wr_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr.lock      <= 1'b0;
      sr.prog_err  <= 1'b0;
      sr.erase_err <= 1'b0;
      sr.prot      <= '0;
      sr.wlatch    <= 1'b0;
      job_q        <= JOB_WRSR;
      wr_ack       <= 1'b0;
      wr_nak       <= 1'b0;
    end else begin
      wr_ack <= wr_grant;
      wr_nak <= wr_try && !wr_grant;
      if (wr_grant) begin
        job_q <= prog_try ? JOB_PROG : (erase_try ? JOB_ERASE : JOB_WRSR);
        if (wrsr_try) begin
          sr.lock <= merge_wrsr(sr, frame_data).lock;
          sr.prot <= merge_wrsr(sr, frame_data).prot;
        end else begin
          sr.prog_err  <= 1'b0;
          sr.erase_err <= 1'b0;
        end
      end
      if (eng_done && eng_fault) begin
        if (job_q == JOB_PROG)  sr.prog_err  <= 1'b1;
        if (job_q == JOB_ERASE) sr.erase_err <= 1'b1;
      end
      if (eng_done)        sr.wlatch <= 1'b0;
      else if (wren_exec)  sr.wlatch <= 1'b1;
      else if (wrdis_exec) sr.wlatch <= 1'b0;
    end
  end

  assign sr.busy = wip;

  // R1: the two strobes never fire together
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && wr_nak));

  // R6: the write latch only rises through the set-latch command
  a_r6_latch_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr.wlatch) |-> $past(wren_exec));

  // R7: an accept needs the latch set in the deciding cycle
  a_r7_ack_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(sr.wlatch));

  // R8: the latch is clear right after the engine finishes
  a_r8_latch_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !sr.wlatch);

  // R9: a locked status write is never accepted
  a_r9_lock_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_try && sr.lock && !wp_n) |=> (wr_nak && !wr_ack));

  // R13: the engine is never restarted while busy
  a_r13_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !wip);

endmodule

// File: tb/flash_sr_ctrl_tb.sv
module flash_sr_ctrl_tb;
  import flash_sr_pkg::*;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1, fault = 1'b0;
  logic [15:0] blen = 16'd20;
  logic        so, so_en, ack, nak;

  always #2 clk = ~clk;

  flash_sr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .wp_n(wp_n), .busy_len(blen), .eng_fault(fault),
    .spi_so(so), .spi_so_en(so_en), .wr_ack(ack), .wr_nak(nak)
  );

  int vecs = 0, bad = 0, ack_cnt = 0, nak_cnt = 0, oe_err = 0;
  bit finished = 1'b0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];

  // Bench model of the register
  logic m_lock = 0, m_perr = 0, m_eerr = 0, m_wel = 0;
  logic [2:0] m_prot = 0;

  function automatic logic [7:0] exp_sr(logic busy);
    return {m_lock, m_perr, m_eerr, m_prot, m_wel, busy};
  endfunction

  always @(negedge clk) begin
    if (rst_n && ack) ack_cnt++;
    if (rst_n && nak) nak_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic v, input int b, input bit rd);
    sck = 1'b0; si = v;
    repeat (H) @(negedge clk);
    if (b < 8) rxb[b] = {rxb[b][6:0], so};
    if (rd && b > 0 && !so_en) oe_err++;
    sck = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame(input int nb, input int xbits, input bit m3, input bit rd);
    sck = m3;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < nb; b++)
      for (int i = 7; i >= 0; i--) bit_cyc(txb[b][i], b, rd);
    for (int i = 0; i < xbits; i++) bit_cyc(1'b1, 7, 1'b0);
    repeat (H) @(negedge clk);
    if (!m3) begin sck = 1'b0; repeat (H) @(negedge clk); end
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op, input bit m3);
    txb[0] = op;
    frame(1, 0, m3, 1'b0);
  endtask

  task automatic wrsr(input logic [7:0] d, input bit m3);
    txb[0] = OP_WRSR; txb[1] = d;
    frame(2, 0, m3, 1'b0);
  endtask

  task automatic rdsr(input int nb, input bit m3);
    txb[0] = OP_RDSR;
    for (int i = 1; i < 8; i++) txb[i] = 8'h00;
    oe_err = 0;
    frame(nb, 0, m3, 1'b1);
  endtask

  task automatic check_sr(input string req, input bit m3);
    rdsr(2, m3);
    chk(rxb[1] == exp_sr(1'b0), req, rxb[1], exp_sr(1'b0));
    chk(oe_err == 0 && !so_en, {req, " R12 output enable"}, oe_err, 0);
  endtask

  task automatic strobes(input string req, input int a0, input int n0, input int ea, input int en);
    chk((ack_cnt - a0) == ea && (nak_cnt - n0) == en, req,
        {16'(ack_cnt - a0), 16'(nak_cnt - n0)}, {16'(ea), 16'(en)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; vecs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int a0, n0, dummy;
    dummy = $urandom(32'h5EED_0042);
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state
    chk(!so_en && !ack && !nak, "R1 reset outputs", {so_en, ack, nak}, 0);
    check_sr("R1 reset status", 1'b0);

    // R5: latch set then clear, both modes
    cmd1(OP_WREN, 1'b0); m_wel = 1;
    check_sr("R5 set latch mode0", 1'b1);
    cmd1(OP_WRDIS, 1'b1); m_wel = 0;
    check_sr("R5 clear latch mode3", 1'b0);

    // R10: set-latch aborted off a byte boundary, and two-byte frame
    txb[0] = OP_WREN; frame(1, 3, 1'b0, 1'b0);
    check_sr("R10 aborted set latch", 1'b0);
    txb[0] = OP_WREN; txb[1] = 8'h00; frame(2, 0, 1'b1, 1'b0);
    check_sr("R5 two-byte set latch ignored", 1'b1);

    // R7: status write with latch clear is rejected
    a0 = ack_cnt; n0 = nak_cnt;
    wrsr(8'h9C, 1'b0);
    strobes("R7 reject strobe", a0, n0, 0, 1);
    check_sr("R7 no change", 1'b0);

    // R6: data 0xFF only lands on lock and protect
    cmd1(OP_WREN, 1'b0);
    a0 = ack_cnt; n0 = nak_cnt;
    wrsr(8'hFF, 1'b1);
    strobes("R8 accept strobe", a0, n0, 1, 0);
    repeat (40) @(negedge clk);
    m_lock = 1; m_prot = 3'd7; m_wel = 0;
    check_sr("R6 merge 0xFF -> 0x9C", 1'b0);

    // R9: locked with pin low -> reject; pin high -> accept
    wp_n = 1'b0;
    cmd1(OP_WREN, 1'b0); m_wel = 1;
    a0 = ack_cnt; n0 = nak_cnt;
    wrsr(8'h00, 1'b0);
    strobes("R9 locked reject", a0, n0, 0, 1);
    check_sr("R9 locked unchanged", 1'b0);
    wp_n = 1'b1;
    a0 = ack_cnt; n0 = nak_cnt;
    wrsr(8'h08, 1'b1);
    strobes("R9 pin high accept", a0, n0, 1, 0);
    repeat (40) @(negedge clk);
    m_lock = 0; m_prot = 3'd2; m_wel = 0;
    check_sr("R9 unlocked write", 1'b0);

    // R10: status write cut mid-byte
    cmd1(OP_WREN, 1'b0); m_wel = 1;
    a0 = ack_cnt; n0 = nak_cnt;
    txb[0] = OP_WRSR; txb[1] = 8'h1C; frame(1, 4, 1'b0, 1'b0);
    strobes("R10 no strobe on abort", a0, n0, 0, 0);
    check_sr("R10 abort unchanged", 1'b1);

    // R3/R4: long busy, streamed read sees busy then idle
    blen = 16'd340;
    wrsr(8'h10, 1'b0);
    m_prot = 3'd4;
    rdsr(5, 1'b1);
    chk(rxb[1] == exp_sr(1'b1), "R4 read while busy", rxb[1], exp_sr(1'b1));
    chk(rxb[2] == exp_sr(1'b1), "R3 second byte busy", rxb[2], exp_sr(1'b1));
    m_wel = 0;
    chk(rxb[4] == exp_sr(1'b0), "R3 live value after done", rxb[4], exp_sr(1'b0));
    chk(oe_err == 0, "R12 enable in read data phase", oe_err, 0);

    // R13: while busy, write-class rejected and set-latch ignored
    blen = 16'd1000;
    cmd1(OP_WREN, 1'b0);
    wrsr(8'h00, 1'b0);
    a0 = ack_cnt; n0 = nak_cnt;
    wrsr(8'h04, 1'b1);
    strobes("R13 busy reject", a0, n0, 0, 1);
    cmd1(OP_WREN, 1'b0);
    repeat (1100) @(negedge clk);
    m_prot = 3'd0; m_wel = 0;
    check_sr("R13 set latch ignored while busy", 1'b0);
    blen = 16'd20;

    // R11: program with fault, erase length rules
    fault = 1'b1;
    cmd1(OP_WREN, 1'b0);
    a0 = ack_cnt; n0 = nak_cnt;
    txb[0] = OP_PROG; txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'h56; txb[4] = 8'hA5;
    frame(5, 0, 1'b0, 1'b0);
    strobes("R11 program accept", a0, n0, 1, 0);
    repeat (40) @(negedge clk);
    m_perr = 1;
    check_sr("R11 program error bit6", 1'b1);
    fault = 1'b0;
    cmd1(OP_WREN, 1'b0); m_wel = 1;
    a0 = ack_cnt; n0 = nak_cnt;
    txb[0] = OP_ERASE; frame(3, 0, 1'b1, 1'b0);
    strobes("R11 short erase ignored", a0, n0, 0, 0);
    txb[0] = OP_ERASE; frame(4, 0, 1'b1, 1'b0);
    strobes("R11 erase accept", a0, n0, 1, 0);
    repeat (40) @(negedge clk);
    m_perr = 0; m_wel = 0;
    check_sr("R11 errors cleared", 1'b0);

    // Constrained random mix
    for (int it = 0; it < 48; it++) begin
      int  sel, ea, en, nb;
      bit  m3;
      logic [7:0] d;
      sel = $urandom_range(0, 6);
      m3  = 1'($urandom_range(0, 1));
      wp_n  = 1'($urandom_range(0, 1));
      fault = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      ea = 0; en = 0;
      a0 = ack_cnt; n0 = nak_cnt;
      case (sel)
        0: begin cmd1(OP_WREN, m3); m_wel = 1; end
        1: begin cmd1(OP_WRDIS, m3); m_wel = 0; end
        2, 3: begin
          wrsr(d, m3);
          if (m_wel && !(m_lock && !wp_n)) begin
            ea = 1; m_lock = d[7]; m_prot = d[4:2]; m_wel = 0;
          end else en = 1;
        end
        4, 5: begin
          nb = (sel == 4) ? $urandom_range(4, 6) : 4;
          txb[0] = (sel == 4) ? OP_PROG : OP_ERASE;
          for (int i = 1; i < 8; i++) txb[i] = 8'($urandom);
          frame(nb, 0, m3, 1'b0);
          if (m_wel) begin
            ea = 1; m_wel = 0;
            m_perr = (sel == 4) ? fault : 1'b0;
            m_eerr = (sel == 5) ? fault : 1'b0;
          end else en = 1;
        end
        default: begin
          txb[0] = ($urandom_range(0, 1) != 0) ? OP_WREN : OP_WRSR;
          txb[1] = d;
          frame(1, $urandom_range(1, 7), m3, 1'b0);
        end
      endcase
      repeat (40) @(negedge clk);
      strobes("R7 R8 random strobes", a0, n0, ea, en);
      check_sr("R2 random status", m3);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule